// File: doc/BRIEF.md
# Serial Link Initiator Error Monitor

This block sits beside the initiator of a clocked serial link. It watches the acknowledge phase that follows the last transfer cycle of each transaction. It counts wait cycles against a programmable limit. In the acknowledge cycle it samples the data lines and the target's error line. It also checks the two parity bits that arrive with each received data beat.

Every problem found sets a detail flag in a status register. One summary flag covers all the detail flags. Software clears the summary flag by writing 1 to it, and that write clears every detail flag along with it. While any error is still pending, the block does not start a new transaction. It turns the request into an IDLE command and records that it cancelled the request.

Software reaches the block through a byte-wide register port with two addresses. The link-side serial datapath drives the transaction strobes and the sampled line values.

Top module: `link_err_monitor`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the status register (address 1) reads 0x00, and done_o and idle_cmd_o are low.
- R2: The control register holds the enable bit at bit 0 and the 4-bit timeout at bits 7:4. Once enable has been written as 1, later writes to the timeout field are ignored while special_mode_i is low. They take effect at any time while special_mode_i is high.
- R3: A start_i request is ignored while enable is 0: no done_o pulse, no idle_cmd_o pulse and no status change follow.
- R4: The acknowledge phase begins in the cycle after last_xfer_i. With timeout value N, the block accepts ack_i in acknowledge cycles 0 to N. If no ack_i has come by the end of cycle N, it ends the transaction and sets the timeout flag (status bit 2). A value of 0 allows no wait cycle.
- R5: If link_data_i is not all ones in the cycle ack_i is accepted, the acknowledge error flag (status bit 1) is set.
- R6: If link_err_i is high in the cycle ack_i is accepted, the transaction error flag (status bit 3) is set.
- R7: On each rx_beat_i, link_par_i[0] must equal the XOR of the even-indexed data bits and link_par_i[1] must equal the XOR of the odd-indexed data bits. A mismatch sets the parity error flag (status bit 4). The received parity pair is held in status bits 7:6.
- R8: Status bit 0 is the OR of the detail flags. Writing 1 to bit 0 clears all detail flags. Any write with bit 0 at 0 changes nothing.
- R9: If a new error and a clearing write arrive in the same cycle, the new error's flag is set and older flags are cleared.
- R10: A start_i request while status bit 0 is set starts no transaction. One cycle later idle_cmd_o pulses, and the cancel flag (status bit 5) is set.
- R11: done_o pulses for one cycle, one cycle after the acknowledge cycle that accepted ack_i or that timed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| special_mode_i | input | 1 | Allows the timeout field to be rewritten after enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| start_i | input | 1 | Transaction request |
| last_xfer_i | input | 1 | Last transfer cycle of the current transaction |
| ack_i | input | 1 | Acknowledge strobe from the target |
| link_data_i | input | DATA_W | Sampled data lines |
| link_err_i | input | 1 | Target error line |
| rx_beat_i | input | 1 | A received data beat with parity is valid |
| link_par_i | input | 2 | Received parity bits |
| done_o | output | 1 | Transaction finished (pulse) |
| idle_cmd_o | output | 1 | Request replaced by an IDLE command (pulse) |

## Verification
Flags appear in the status read one cycle after the edge that samples the event, because reads are combinational over registered flags. done_o and idle_cmd_o are registered, so each is due one edge after the deciding cycle. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the one that drops last_xfer_i, which gives the acknowledge cycle index at which done_o first rises. It compares that index with the smaller of the programmed timeout and the ack delay. Register writes are read back only after the following rising edge has passed.

// File: rtl/link_err_pkg.sv
package link_err_pkg;
  localparam int unsigned TMO_W     = 4;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned TMO_LSB   = 4;
  localparam int unsigned CLR_BIT   = 0;
  localparam logic        ADDR_CTRL = 1'b0;
  localparam logic        ADDR_STAT = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_ACK  = 2'd2
  } lnk_state_e;

  // status bits 5:1, top to bottom
  typedef struct packed {
    logic cancel;
    logic parity;
    logic txn;
    logic tmo;
    logic ack;
  } err_flags_t;
endpackage

// File: rtl/lem_ctrl_regs.sv
module lem_ctrl_regs
  import link_err_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             special_i,
  input  logic             we_i,
  input  logic             en_wr_i,
  input  logic [TMO_W-1:0] tmo_wr_i,
  output logic             en_o,
  output logic [TMO_W-1:0] tmo_o
);
  logic             en_q;
  logic             lock_q;
  logic [TMO_W-1:0] tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      tmo_q  <= '0;
    end else if (we_i) begin
      en_q <= en_wr_i;
      if (en_wr_i) lock_q <= 1'b1;
      if (!lock_q || special_i) tmo_q <= tmo_wr_i;
    end
  end

  assign en_o  = en_q;
  assign tmo_o = tmo_q;

  a_r2_tmo_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !special_i && we_i) |=> (tmo_q == $past(tmo_q)));
endmodule

// File: rtl/lem_parity_chk.sv
module lem_parity_chk #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        par_i,
  output logic              par_err_o,
  output logic [1:0]        rx_par_o
);
  logic [1:0] exp_par;
  logic [1:0] rx_par_q;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_comb begin
      exp_par[g] = 1'b0;
      for (int i = g; i < int'(DATA_W); i += 2) exp_par[g] ^= data_i[i];
    end
  end

  assign par_err_o = beat_i && (exp_par != par_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_par_q <= '0;
    else if (beat_i) rx_par_q <= par_i;
  end

  assign rx_par_o = rx_par_q;

  a_r7_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_i |=> $stable(rx_par_q));
endmodule

// File: rtl/lem_ack_fsm.sv
module lem_ack_fsm
  import link_err_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              err_pend_i,
  input  logic [TMO_W-1:0]  tmo_i,
  input  logic              start_i,
  input  logic              last_xfer_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              link_err_i,
  output logic              ev_ack_o,
  output logic              ev_txn_o,
  output logic              ev_tmo_o,
  output logic              ev_cancel_o,
  output logic              done_o,
  output logic              idle_cmd_o
);
  lnk_state_e       state_q, state_d;
  logic [TMO_W-1:0] wcnt_q, wcnt_d;
  logic             fin;
  logic             done_q, idle_q;

  always_comb begin
    state_d     = state_q;
    wcnt_d      = wcnt_q;
    fin         = 1'b0;
    ev_ack_o    = 1'b0;
    ev_txn_o    = 1'b0;
    ev_tmo_o    = 1'b0;
    ev_cancel_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && en_i) begin
          if (err_pend_i) ev_cancel_o = 1'b1;
          else            state_d     = ST_XFER;
        end
      end
      ST_XFER: begin
        if (last_xfer_i) begin
          state_d = ST_ACK;
          wcnt_d  = '0;
        end
      end
      ST_ACK: begin
        if (ack_i) begin
          ev_ack_o = ~&data_i;
          ev_txn_o = link_err_i;
          fin      = 1'b1;
          state_d  = ST_IDLE;
        end else if (wcnt_q >= tmo_i) begin
          ev_tmo_o = 1'b1;
          fin      = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      done_q  <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      done_q  <= fin;
      idle_q  <= ev_cancel_o;
    end
  end

  assign done_o     = done_q;
  assign idle_cmd_o = idle_q;

  a_r11_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && ack_i) |=> done_o);
  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_cancel_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_cmd_o |-> (state_q == ST_IDLE && !done_o));
  a_r3_disabled_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !en_i) |=> (state_q == ST_IDLE && !idle_cmd_o));
endmodule

// File: rtl/lem_status.sv
module lem_status
  import link_err_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  err_flags_t new_i,
  output err_flags_t flags_o,
  output logic       summary_o
);
  err_flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (clr_i ? err_flags_t'('0) : flags_q) | new_i;
  end

  assign flags_o   = flags_q;
  assign summary_o = |flags_q;

  a_r8_fall_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(summary_o) |-> $past(clr_i));
  a_r9_new_error_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|new_i) |=> summary_o);
endmodule

// File: rtl/link_err_monitor.sv
module link_err_monitor
  import link_err_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              special_mode_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              start_i,
  input  logic              last_xfer_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] link_data_i,
  input  logic              link_err_i,
  input  logic              rx_beat_i,
  input  logic [1:0]        link_par_i,
  output logic              done_o,
  output logic              idle_cmd_o
);
  logic             en;
  logic [TMO_W-1:0] tmo;
  logic             ctrl_we, clr;
  logic             ev_ack, ev_txn, ev_tmo, ev_cancel, ev_par;
  logic [1:0]       rx_par;
  err_flags_t       new_err, flags;
  logic             summary;

  assign ctrl_we = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign clr     = reg_we_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[CLR_BIT];

  lem_ctrl_regs u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .special_i (special_mode_i),
    .we_i      (ctrl_we),
    .en_wr_i   (reg_wdata_i[EN_BIT]),
    .tmo_wr_i  (reg_wdata_i[TMO_LSB +: TMO_W]),
    .en_o      (en),
    .tmo_o     (tmo)
  );

  lem_ack_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .err_pend_i  (summary),
    .tmo_i       (tmo),
    .start_i     (start_i),
    .last_xfer_i (last_xfer_i),
    .ack_i       (ack_i),
    .data_i      (link_data_i),
    .link_err_i  (link_err_i),
    .ev_ack_o    (ev_ack),
    .ev_txn_o    (ev_txn),
    .ev_tmo_o    (ev_tmo),
    .ev_cancel_o (ev_cancel),
    .done_o      (done_o),
    .idle_cmd_o  (idle_cmd_o)
  );

  lem_parity_chk #(.DATA_W(DATA_W)) u_par (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .beat_i    (rx_beat_i),
    .data_i    (link_data_i),
    .par_i     (link_par_i),
    .par_err_o (ev_par),
    .rx_par_o  (rx_par)
  );

  always_comb begin
    new_err        = '0;
    new_err.ack    = ev_ack;
    new_err.txn    = ev_txn;
    new_err.tmo    = ev_tmo;
    new_err.cancel = ev_cancel;
    new_err.parity = ev_par;
  end

  lem_status u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .new_i     (new_err),
    .flags_o   (flags),
    .summary_o (summary)
  );

  always_comb begin
    if (reg_addr_i == ADDR_CTRL) reg_rdata_o = {tmo, 3'b000, en};
    else                         reg_rdata_o = {rx_par, flags, summary};
  end

  a_r10_cancel_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_cmd_o |-> flags.cancel);
endmodule

// File: tb/link_err_monitor_tb.sv
module link_err_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {tmo[3:0], delay[4:0], data[7:0], err, exp_status[5:0]}
  localparam logic [23:0] VECS [NVEC] = '{
    {4'd0,  5'd0,  8'hFF, 1'b0, 6'h00},
    {4'd0,  5'd1,  8'hFF, 1'b0, 6'h05},
    {4'd3,  5'd3,  8'hFF, 1'b0, 6'h00},
    {4'd3,  5'd4,  8'hFF, 1'b0, 6'h05},
    {4'd2,  5'd0,  8'hF7, 1'b0, 6'h03},
    {4'd2,  5'd1,  8'hFF, 1'b1, 6'h09},
    {4'd15, 5'd15, 8'hFF, 1'b0, 6'h00},
    {4'd15, 5'd16, 8'hFF, 1'b0, 6'h05},
    {4'd1,  5'd0,  8'h00, 1'b1, 6'h0B}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special = 1'b0;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       start = 1'b0, last_xfer = 1'b0, ack = 1'b0;
  logic [7:0] ldata = 8'hFF;
  logic       lerr = 1'b0, beat = 1'b0;
  logic [1:0] lpar = '0;
  logic       done, idle_cmd;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_err_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .special_mode_i(special),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .start_i(start), .last_xfer_i(last_xfer), .ack_i(ack),
    .link_data_i(ldata), .link_err_i(lerr), .rx_beat_i(beat), .link_par_i(lpar),
    .done_o(done), .idle_cmd_o(idle_cmd)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  // runs one transaction; returns acknowledge cycle index of completion, -1 if none
  task automatic run_txn(input int dly, output int first);
    first = -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; last_xfer = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done && first < 0) first = k - 1;
      last_xfer = 1'b0;
      ack = (k == dly);
    end
    ack = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int first;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(1'b0, rd); check("R1 ctrl", rd, 8'h00);
    reg_rd(1'b1, rd); check("R1 status", rd, 8'h00);
    check("R1 done", {7'b0, done}, 8'h00);
    check("R1 idle_cmd", {7'b0, idle_cmd}, 8'h00);

    // R3 start ignored while disabled
    run_txn(0, first);
    check("R3 no done", first[7:0], 8'hFF);
    reg_rd(1'b1, rd); check("R3 status", rd, 8'h00);

    // R2 write-once timeout
    reg_wr(1'b0, 8'h21);
    reg_rd(1'b0, rd); check("R2 first write", rd, 8'h21);
    reg_wr(1'b0, 8'h51);
    reg_rd(1'b0, rd); check("R2 locked", rd, 8'h21);
    special = 1'b1;
    reg_wr(1'b0, 8'h51);
    reg_rd(1'b0, rd); check("R2 special", rd, 8'h51);

    // R4 R5 R6 R11 vector walk
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] t;
      int dly;
      int exp_done;
      t = VECS[v][23:20];
      dly = int'(VECS[v][19:15]);
      ldata = VECS[v][14:7];
      lerr = VECS[v][6];
      reg_wr(1'b0, {t, 4'h1});
      reg_wr(1'b1, 8'h01);
      run_txn(dly, first);
      exp_done = (dly <= int'(t)) ? dly : int'(t);
      check("R11/R4 done cycle", first[7:0], exp_done[7:0]);
      reg_rd(1'b1, rd);
      check("R4/R5/R6 status", {2'b00, rd[5:0]}, {2'b00, VECS[v][5:0]});
      ldata = 8'hFF; lerr = 1'b0;
    end

    // R7 parity
    reg_wr(1'b1, 8'h01);
    @(negedge clk); beat = 1'b1; ldata = 8'h03; lpar = 2'b11;
    @(negedge clk); beat = 1'b0;
    reg_rd(1'b1, rd); check("R7 good parity", rd, 8'hC0);
    @(negedge clk); beat = 1'b1; ldata = 8'h03; lpar = 2'b01;
    @(negedge clk); beat = 1'b0;
    reg_rd(1'b1, rd); check("R7 odd lane mismatch", rd, 8'h51);
    reg_wr(1'b1, 8'h01);
    @(negedge clk); beat = 1'b1; ldata = 8'h04; lpar = 2'b01;
    @(negedge clk); beat = 1'b0; ldata = 8'hFF;
    reg_rd(1'b1, rd); check("R7 even lane good", rd, 8'h40);

    // R8 write-zero has no effect
    @(negedge clk); beat = 1'b1; ldata = 8'h03; lpar = 2'b00;
    @(negedge clk); beat = 1'b0; ldata = 8'hFF;
    reg_wr(1'b1, 8'h00);
    reg_rd(1'b1, rd); check("R8 write 0", rd, 8'h11);
    reg_wr(1'b1, 8'hFE);
    reg_rd(1'b1, rd); check("R8 write FE", rd, 8'h11);
    reg_wr(1'b1, 8'h01);
    reg_rd(1'b1, rd); check("R8 w1c", rd, 8'h00);

    // R9 clear and new error together
    lerr = 1'b1;
    run_txn(0, first);
    lerr = 1'b0;
    reg_rd(1'b1, rd); check("R9 pre", rd, 8'h09);
    @(negedge clk); we = 1'b1; addr = 1'b1; wdata = 8'h01;
    beat = 1'b1; ldata = 8'h03; lpar = 2'b00;
    @(negedge clk); we = 1'b0; beat = 1'b0; ldata = 8'hFF;
    reg_rd(1'b1, rd); check("R9 new wins", rd, 8'h11);

    // R10 cancel while pending
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R10 idle_cmd", {7'b0, idle_cmd}, 8'h01);
    @(negedge clk);
    check("R10 idle_cmd pulse", {7'b0, idle_cmd}, 8'h00);
    reg_rd(1'b1, rd); check("R10 cancel flag", rd, 8'h31);
    last_xfer = 1'b1;
    @(negedge clk); last_xfer = 1'b0; ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    @(negedge clk);
    check("R10 no transaction", {7'b0, done}, 8'h00);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule